// File: doc/BRIEF.md
# Divide Ratio Factor Splitter

This unit takes the total divide ratio wanted from a two-stage cascaded clock divider and breaks it into one factor per stage. A requester drives a ratio and pulses `start`. The unit runs a short sequential search and returns the two stage factors with a one-cycle `done` pulse. If the ratio cannot be built from two factors in the range 1 to 8, it raises `err` in that same pulse.

The ratio is first limited to 64, the largest product two stages can reach. Ratios of 0 and 1 need no search and are answered at once as a pair of ones. Any other ratio is tested against second-stage candidates, one per clock, in increasing order from 2. The first candidate that divides the ratio exactly and leaves a quotient of 8 or less is taken. The quotient goes to the first stage and the candidate goes to the second stage. While a search is running, `busy` is high and any new `start` has no effect.

Top module: `ratio_split`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy`, `done` and `err` are low and `fac_a` and `fac_b` are zero.
- R2: A ratio above 64 is treated exactly as 64. The result is `fac_a`=8, `fac_b`=8, with `done` high in cycle 8, counting the cycle in which `start` was high as cycle 0.
- R3: A ratio of 0 or 1 gives `fac_a`=1, `fac_b`=1 and `err`=0, with `done` high in cycle 1 and `busy` never raised.
- R4: Second-stage candidates are tested in increasing order from 2 to 8, one per clock. When candidate c is accepted, `done` is high in cycle c. When no candidate is accepted, `done` is high in cycle 8.
- R5: A candidate is accepted when it divides the clamped ratio with no remainder and the quotient is at most 8. On acceptance, `fac_a` carries the quotient, `fac_b` carries the candidate and `err` is 0. All three are valid while `done` is high.
- R6: When no candidate from 2 to 8 is accepted, `done` is accompanied by `err`=1 with `fac_a`=0 and `fac_b`=0.
- R7: For a search, `busy` is high from cycle 1 up to the cycle before `done`, and `busy` is never high in the same cycle as `done`.
- R8: A `start` that arrives while `busy` is high is ignored. It causes no extra `done` and does not change the pending result.
- R9: A `start` that arrives in a cycle where `done` is high and `busy` is low is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request; sampled at the clock edge when the unit is idle |
| ratio | input | RATIO_W | Requested total divide ratio |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| fac_a | output | $clog2(MAX_FACTOR+1) | First-stage factor (quotient) |
| fac_b | output | $clog2(MAX_FACTOR+1) | Second-stage factor (accepted candidate) |
| err | output | 1 | No valid factor pair, valid with `done` |

## Verification
Two events can fall in the same cycle: one search ending with its `done` pulse and a new request being accepted. They coincide because `busy` drops on the same edge that raises `done`. The bench provokes this by holding `start` high for a long run of cycles while changing `ratio` part way through. Requests that arrive during a search must be dropped, and the request present in the `done` cycle must start the next answer. A trivial ratio accepted in a `done` cycle produces two `done` pulses back to back. A cycle-accurate behavioural model predicts `busy`, `done` and the result on every clock, and the design is judged against that model.

// File: rtl/rsplit_pkg.sv
package rsplit_pkg;
  typedef enum logic [0:0] {
    RS_IDLE   = 1'b0,
    RS_SEARCH = 1'b1
  } rs_state_t;
endpackage

// File: rtl/rsplit_clamp.sv
// Limits the incoming ratio to the largest two-stage product and flags
// the trivial requests (0 or 1) that bypass the search.
module rsplit_clamp #(
  parameter int RATIO_W = 8,
  parameter int LIMIT   = 64,
  parameter int LIMIT_W = 7
) (
  input  logic [RATIO_W-1:0] ratio,
  output logic [LIMIT_W-1:0] clamped,
  output logic               trivial
);
  logic [31:0] wide;

  always_comb begin
    wide    = 32'(ratio);
    clamped = (wide > 32'(LIMIT)) ? LIMIT_W'(LIMIT) : LIMIT_W'(wide);
    trivial = (wide <= 32'd1);
  end
endmodule

// File: rtl/rsplit_probe.sv
// Tests one candidate against the held ratio. Each candidate has its own
// constant divider, and the current candidate selects among them.
module rsplit_probe #(
  parameter int MAX_FACTOR = 8,
  parameter int LIMIT_W    = 7,
  parameter int FACT_W     = 4
) (
  input  logic [LIMIT_W-1:0] r,
  input  logic [FACT_W-1:0]  cand,
  output logic               hit,
  output logic [FACT_W-1:0]  quo
);
  logic              k_hit [2:MAX_FACTOR];
  logic [FACT_W-1:0] k_quo [2:MAX_FACTOR];

  for (genvar k = 2; k <= MAX_FACTOR; k++) begin : g_cand
    logic [LIMIT_W-1:0] q_full;
    logic [LIMIT_W-1:0] rem;
    always_comb begin
      q_full   = r / LIMIT_W'(k);
      rem      = r % LIMIT_W'(k);
      k_hit[k] = (rem == '0) && (q_full <= LIMIT_W'(MAX_FACTOR));
      k_quo[k] = FACT_W'(q_full);
    end
  end

  always_comb begin
    hit = 1'b0;
    quo = '0;
    for (int i = 2; i <= MAX_FACTOR; i++) begin
      if (cand == FACT_W'(i)) begin
        hit = k_hit[i];
        quo = k_quo[i];
      end
    end
  end
endmodule

// File: rtl/rsplit_ctrl.sv
// Sequencer: accepts a request when idle, steps the candidate once per
// clock and registers the result together with the done strobe.
module rsplit_ctrl
  import rsplit_pkg::*;
#(
  parameter int MAX_FACTOR = 8,
  parameter int LIMIT_W    = 7,
  parameter int FACT_W     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [LIMIT_W-1:0] clamped,
  input  logic               trivial,
  input  logic               probe_hit,
  input  logic [FACT_W-1:0]  probe_quo,
  output logic [LIMIT_W-1:0] r_held,
  output logic [FACT_W-1:0]  cand,
  output logic               busy,
  output logic               done,
  output logic [FACT_W-1:0]  fac_a,
  output logic [FACT_W-1:0]  fac_b,
  output logic               err
);
  rs_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= RS_IDLE;
      r_held <= '0;
      cand   <= '0;
      done   <= 1'b0;
      fac_a  <= '0;
      fac_b  <= '0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        RS_IDLE: begin
          if (start) begin
            if (trivial) begin
              done  <= 1'b1;
              fac_a <= FACT_W'(1);
              fac_b <= FACT_W'(1);
              err   <= 1'b0;
            end else begin
              r_held <= clamped;
              cand   <= FACT_W'(2);
              state  <= RS_SEARCH;
            end
          end
        end
        RS_SEARCH: begin
          if (probe_hit) begin
            done  <= 1'b1;
            fac_a <= probe_quo;
            fac_b <= cand;
            err   <= 1'b0;
            state <= RS_IDLE;
          end else if (cand == FACT_W'(MAX_FACTOR)) begin
            done  <= 1'b1;
            fac_a <= '0;
            fac_b <= '0;
            err   <= 1'b1;
            state <= RS_IDLE;
          end else begin
            cand <= cand + FACT_W'(1);
          end
        end
        default: state <= RS_IDLE;
      endcase
    end
  end

  assign busy = (state == RS_SEARCH);
endmodule

// File: rtl/ratio_split.sv
module ratio_split #(
  parameter int RATIO_W    = 8,
  parameter int MAX_FACTOR = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic [RATIO_W-1:0]                ratio,
  output logic                              busy,
  output logic                              done,
  output logic [$clog2(MAX_FACTOR+1)-1:0]   fac_a,
  output logic [$clog2(MAX_FACTOR+1)-1:0]   fac_b,
  output logic                              err
);
  localparam int LIMIT   = MAX_FACTOR * MAX_FACTOR;
  localparam int LIMIT_W = $clog2(LIMIT + 1);
  localparam int FACT_W  = $clog2(MAX_FACTOR + 1);

  logic [LIMIT_W-1:0] clamped;
  logic               trivial;
  logic [LIMIT_W-1:0] r_held;
  logic [FACT_W-1:0]  cand;
  logic               probe_hit;
  logic [FACT_W-1:0]  probe_quo;

  rsplit_clamp #(
    .RATIO_W(RATIO_W), .LIMIT(LIMIT), .LIMIT_W(LIMIT_W)
  ) u_clamp (
    .ratio(ratio), .clamped(clamped), .trivial(trivial)
  );

  rsplit_probe #(
    .MAX_FACTOR(MAX_FACTOR), .LIMIT_W(LIMIT_W), .FACT_W(FACT_W)
  ) u_probe (
    .r(r_held), .cand(cand), .hit(probe_hit), .quo(probe_quo)
  );

  rsplit_ctrl #(
    .MAX_FACTOR(MAX_FACTOR), .LIMIT_W(LIMIT_W), .FACT_W(FACT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .clamped(clamped), .trivial(trivial),
    .probe_hit(probe_hit), .probe_quo(probe_quo),
    .r_held(r_held), .cand(cand),
    .busy(busy), .done(done),
    .fac_a(fac_a), .fac_b(fac_b), .err(err)
  );
endmodule

// File: rtl/rsplit_chk.sv
module rsplit_chk #(
  parameter int MAX_FACTOR = 8,
  parameter int FACT_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [FACT_W-1:0] fac_a,
  input logic [FACT_W-1:0] fac_b
);
  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R8
  busy_exit_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (fac_a == '0 && fac_b == '0));

  // R5
  pair_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (int'(fac_a) >= 1 && int'(fac_a) <= MAX_FACTOR &&
                        int'(fac_b) >= 1 && int'(fac_b) <= MAX_FACTOR));

  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

bind ratio_split rsplit_chk #(
  .MAX_FACTOR(MAX_FACTOR), .FACT_W($clog2(MAX_FACTOR + 1))
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .err(err), .fac_a(fac_a), .fac_b(fac_b)
);

// File: tb/sim_ratio_split.sv
`timescale 1ns/1ps
module sim_ratio_split;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] ratio = '0;
  logic       busy, done, err;
  logic [3:0] fac_a, fac_b;

  int vectors = 0;
  int miscompares = 0;
  string tag = "R1";

  // behavioural model state
  int mb = 0, md = 0, cnt = 0, mfa = 0, mfb = 0, merr = 0;
  int pfa = 0, pfb = 0, perr = 0;

  always #2 clk = ~clk;

  ratio_split #(.RATIO_W(8), .MAX_FACTOR(8)) u0 (
    .clk(clk), .rst(rst), .start(start), .ratio(ratio),
    .busy(busy), .done(done), .fac_a(fac_a), .fac_b(fac_b), .err(err)
  );

  function automatic void calc(input int rq, output int fa, output int fb,
                               output int e, output int lat);
    int r;
    r = (rq > 64) ? 64 : rq;
    fa = 1; fb = 1; e = 0; lat = 0;
    if (r <= 1) return;
    for (int c = 2; c <= 8; c++) begin
      if (r % c == 0 && r / c <= 8) begin
        fa = r / c; fb = c; lat = c - 1;
        return;
      end
    end
    fa = 0; fb = 0; e = 1; lat = 7;
  endfunction

  always @(posedge clk) begin
    int fa, fb, e, lat;
    if (rst) begin
      mb = 0; md = 0; cnt = 0; mfa = 0; mfb = 0; merr = 0;
    end else begin
      md = 0;
      if (mb != 0) begin
        cnt--;
        if (cnt == 0) begin
          mb = 0; md = 1; mfa = pfa; mfb = pfb; merr = perr;
        end
      end else if (start) begin
        calc(int'(ratio), fa, fb, e, lat);
        if (lat == 0) begin
          md = 1; mfa = fa; mfb = fb; merr = e;
        end else begin
          mb = 1; cnt = lat; pfa = fa; pfb = fb; perr = e;
        end
      end
    end
  end

  task automatic check(input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check("busy", int'(busy), mb);
    check("done", int'(done), md);
    if (md != 0) begin
      check("fac_a", int'(fac_a), mfa);
      check("fac_b", int'(fac_b), mfb);
      check("err", int'(err), merr);
    end
  endtask

  task automatic request(input int r, input string t);
    tag = t;
    ratio = 8'(r);
    start = 1'b1;
    step();
    start = 1'b0;
    repeat (10) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    tag = "R1";
    check("busy", int'(busy), 0);
    check("done", int'(done), 0);
    check("err", int'(err), 0);
    check("fac_a", int'(fac_a), 0);
    check("fac_b", int'(fac_b), 0);
    rst = 1'b0;
    step();
    // R3: trivial ratios
    request(0, "R3");
    request(1, "R3");
    // R4 / R5: accepted pairs at various candidates
    request(2, "R5");
    request(7, "R4");
    request(9, "R5");
    request(12, "R5");
    request(16, "R4");
    request(48, "R4");
    request(49, "R5");
    request(56, "R5");
    request(64, "R4");
    // R6: no pair exists
    request(11, "R6");
    request(13, "R6");
    request(63, "R6");
    // R2: clamping
    request(65, "R2");
    request(200, "R2");
    request(255, "R2");
    // R8 / R9: start held through searches and done cycles
    tag = "R8";
    ratio = 8'd48;
    start = 1'b1;
    repeat (4) step();
    ratio = 8'd11;
    repeat (5) step();
    tag = "R9";
    ratio = 8'd1;
    repeat (6) step();
    ratio = 8'd49;
    repeat (12) step();
    start = 1'b0;
    repeat (10) step();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule